// File: doc/BRIEF.md
# Descriptor Chain Walker

This block steps through a linked list of three-word transfer descriptors kept in memory, for a single transfer direction. Software supplies the low bits of the first descriptor's address and pulses a start input. The walker then reads the descriptor's three words over a request/acknowledge read port. It validates them and hands the buffer pointer and byte count to an external data mover. Once the mover reports completion it can optionally write the control word back with a chosen ownership value. It then follows the link word to the next descriptor until a zero link ends the chain.

Descriptor layout: word 0 is the control word, with bit 31 = owner (1 means hardware owns the descriptor), bit 30 = end-of-frame, and bits 11:0 = byte count. Word 1 is the buffer address. Word 2 is the link to the next descriptor; an all-zero link ends the chain. The words are read at offsets +0, +4 and +8 from the descriptor address. The walker keeps a three-deep address history, records where the last end-of-frame descriptor (and the one before it) sat, and reports progress with single-cycle event pulses.

Top module: `dscr_chain_walker`

## Requirements
- R1: A start pulse while parked loads `cfg_first_addr` as the current descriptor address and reads words 0, 1 and 2 at that address +0, +4 and +8. Each word is taken in the cycle `rd_ack` is high.
- R2: A stop pulse while busy returns the walker to the parked state on the next clock and drops every request.
- R3: `park` is 1 exactly when the walker is idle. While parked it raises no read, write or mover request, and at most one request is ever high.
- R4: Every move to a new descriptor (start, or following a link) shifts the history: previous-of-previous takes previous, previous takes current, and current takes the new address.
- R5: With `cfg_check_owner` = 1, a descriptor whose control bit 31 is 0 raises `ev_dscr_err` for one cycle, starts no transfer, and parks. With `cfg_check_owner` = 0, bit 31 is ignored.
- R6: A descriptor with byte count 0 and bit 30 clear, or with link bits 1:0 not both zero, raises `ev_dscr_err` and parks without a transfer.
- R7: With `cfg_wb_en` = 1, after the mover completes, the walker writes the control word back to the descriptor address with bit 31 replaced by `cfg_wb_owner` and bits 30:0 unchanged. It finishes the descriptor on `wr_ack`.
- R8: When a descriptor with bit 30 set finishes, `ev_eof` pulses, `eof_dscr_addr` takes its address, and `eof_prev_addr` takes the history entry before it. Other descriptors leave both registers unchanged.
- R9: `ev_done` pulses for one cycle after every descriptor whose data the mover has acknowledged via `mv_done` (and whose write-back has completed, if enabled).
- R10: `ev_total_eof` pulses together with `ev_done` when the finished descriptor has bit 30 set and a zero link. A chain whose last descriptor lacks bit 30 ends without it.
- R11: `soft_rst` parks the walker on the next clock and clears the history and the end-of-frame address registers.
- R12: A restart pulse while parked refetches the descriptor at the current history address without shifting the history.
- R13: After a descriptor finishes with a non-zero link, the next read uses link bits of width `ADDR_W` as the new descriptor address. A byte count of 0 with bit 30 set is a valid descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous walker reset from software |
| ctl_start | input | 1 | Begin at the programmed first address |
| ctl_stop | input | 1 | Abandon processing and park |
| ctl_restart | input | 1 | Resume at the current history address |
| cfg_first_addr | input | ADDR_W | First descriptor address |
| cfg_check_owner | input | 1 | Enable ownership check |
| cfg_wb_en | input | 1 | Enable control-word write-back |
| cfg_wb_owner | input | 1 | Owner value written back |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 32 | Read response word |
| wr_req | output | 1 | Write-back request |
| wr_addr | output | ADDR_W | Write-back byte address |
| wr_data | output | 32 | Write-back control word |
| wr_ack | input | 1 | Write-back accepted |
| mv_req | output | 1 | Data mover request |
| mv_buf_addr | output | 32 | Buffer address for the mover |
| mv_len | output | 12 | Byte count for the mover |
| mv_done | input | 1 | Mover finished the buffer |
| park | output | 1 | Walker idle |
| ev_dscr_err | output | 1 | Descriptor error pulse |
| ev_done | output | 1 | Descriptor finished pulse |
| ev_eof | output | 1 | End-of-frame descriptor finished pulse |
| ev_total_eof | output | 1 | Chain ended on an end-of-frame descriptor |
| hist_cur | output | ADDR_W | Current descriptor address |
| hist_prev | output | ADDR_W | Previous descriptor address |
| hist_prev2 | output | ADDR_W | Descriptor address two steps back |
| eof_dscr_addr | output | ADDR_W | Address of last end-of-frame descriptor |
| eof_prev_addr | output | ADDR_W | Address recorded before that descriptor |

## Verification
The assertions watch, on every cycle, the invariants that hold in any state: no request while parked, never two requests at once, stop and soft reset parking on the next clock, an error always followed by parking, the history shift on each load, end-of-frame capture, and write-back only after a mover completion. Which descriptor faults, which address is fetched, the chain-following order, the ownership-check switch and the written-back word depend on memory contents. Only the bench's scenarios, compared cycle by cycle against its reference model, show those: a full chain, write-back followed by an ownership failure, each malformed case, a chain without end-of-frame, and stop followed by restart.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    localparam int WORD_W    = 32;
    localparam int LEN_W     = 12;
    localparam int OWNER_BIT = 31;
    localparam int EOF_BIT   = 30;
    localparam int N_WORDS   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_MOVE,
        ST_WBACK,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] buf_ptr;
        logic [WORD_W-1:0] link;
    } dscr_t;

    typedef struct packed {
        logic owner;
        logic length;
        logic link;
    } fault_t;

    function automatic fault_t dscr_faults(input dscr_t d, input logic chk_owner);
        fault_t f;
        f.owner  = chk_owner && !d.ctrl[OWNER_BIT];
        f.length = (d.ctrl[LEN_W-1:0] == '0) && !d.ctrl[EOF_BIT];
        f.link   = (d.link[1:0] != 2'b00);
        return f;
    endfunction

    function automatic logic dscr_is_last(input dscr_t d);
        return d.link == '0;
    endfunction

    function automatic logic dscr_is_eof(input dscr_t d);
        return d.ctrl[EOF_BIT];
    endfunction

endpackage

// File: rtl/dcw_ctrl.sv
module dcw_ctrl
    import dcw_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              start,
    input  logic              stop,
    input  logic              restart,
    input  logic              chk_owner,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              mv_done,
    input  logic              wr_ack,
    output walk_state_e       state,
    output logic [1:0]        widx,
    output dscr_t             dscr,
    output logic              hist_load,
    output logic [ADDR_W-1:0] hist_addr,
    output logic              eof_cap
);

    localparam logic [1:0] LAST_WORD = 2'(N_WORDS - 1);

    walk_state_e state_n;
    logic [1:0]  widx_n;
    fault_t      fault;

    assign fault = dscr_faults(dscr, chk_owner);

    always_comb begin
        state_n   = state;
        widx_n    = widx;
        hist_load = 1'b0;
        hist_addr = first_addr;
        eof_cap   = (state == ST_DONE) && dscr_is_eof(dscr);
        if (stop && state != ST_IDLE) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        hist_load = 1'b1;
                        hist_addr = first_addr;
                        widx_n    = '0;
                        state_n   = ST_FETCH;
                    end else if (restart) begin
                        widx_n  = '0;
                        state_n = ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (rd_ack) begin
                        if (widx == LAST_WORD) state_n = ST_CHECK;
                        else                   widx_n  = widx + 2'd1;
                    end
                end
                ST_CHECK: state_n = (|fault) ? ST_FAULT : ST_MOVE;
                ST_MOVE: begin
                    if (mv_done) state_n = wb_en ? ST_WBACK : ST_DONE;
                end
                ST_WBACK: begin
                    if (wr_ack) state_n = ST_DONE;
                end
                ST_DONE: begin
                    if (dscr_is_last(dscr)) begin
                        state_n = ST_IDLE;
                    end else begin
                        hist_load = 1'b1;
                        hist_addr = dscr.link[ADDR_W-1:0];
                        widx_n    = '0;
                        state_n   = ST_FETCH;
                    end
                end
                ST_FAULT: state_n = ST_IDLE;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state <= ST_IDLE;
            widx  <= '0;
            dscr  <= '0;
        end else begin
            state <= state_n;
            widx  <= widx_n;
            if (state == ST_FETCH && rd_ack && !stop) begin
                unique case (widx)
                    2'd0:    dscr.ctrl    <= rd_data;
                    2'd1:    dscr.buf_ptr <= rd_data;
                    default: dscr.link    <= rd_data;
                endcase
            end
        end
    end

    // R7: write-back is only ever entered from a completed move
    assert_wb_after_move_R7: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (state == ST_WBACK) |-> ($past(state) == ST_MOVE || $past(state) == ST_WBACK));

    // R6: a fault cycle is only reached from the check cycle
    assert_fault_from_check_R6: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (state == ST_FAULT) |-> ($past(state) == ST_CHECK));

endmodule

// File: rtl/dcw_hist.sv
module dcw_hist #(
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         load,
    input  logic [ADDR_W-1:0]            addr_in,
    input  logic                         eof_cap,
    output logic [DEPTH-1:0][ADDR_W-1:0] hist_q,
    output logic [ADDR_W-1:0]            eof_addr,
    output logic [ADDR_W-1:0]            eof_prev
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist_q   <= '0;
            eof_addr <= '0;
            eof_prev <= '0;
        end else begin
            if (eof_cap) begin
                eof_addr <= hist_q[0];
                eof_prev <= hist_q[1];
            end
            if (load) begin
                hist_q[0] <= addr_in;
                for (int i = 1; i < DEPTH; i++) begin
                    hist_q[i] <= hist_q[i-1];
                end
            end
        end
    end

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_shift_chk
            // R4: each stage takes the value of the stage in front of it
            assert_hist_shift_R4: assert property (@(posedge clk) disable iff (rst)
                (load && !clr) |=> (hist_q[g] == $past(hist_q[g-1])));
        end
    endgenerate

    // R8: the end-of-frame register takes the current address
    assert_eof_capture_R8: assert property (@(posedge clk) disable iff (rst)
        (eof_cap && !clr) |=> (eof_addr == $past(hist_q[0])));

    // R8: without a capture the end-of-frame register holds
    assert_eof_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!eof_cap && !clr) |=> $stable(eof_addr));

endmodule

// File: rtl/dcw_port.sv
module dcw_port
    import dcw_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  walk_state_e       state,
    input  logic [1:0]        widx,
    input  dscr_t             dscr,
    input  logic [ADDR_W-1:0] cur,
    input  logic              wb_owner,
    output logic              park,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              mv_req,
    output logic [WORD_W-1:0] mv_buf_addr,
    output logic [LEN_W-1:0]  mv_len,
    output logic              ev_dscr_err,
    output logic              ev_done,
    output logic              ev_eof,
    output logic              ev_total_eof
);

    localparam int PAD_W = ADDR_W - 4;

    logic at_done;
    assign at_done = (state == ST_DONE);

    assign park         = (state == ST_IDLE);
    assign rd_req       = (state == ST_FETCH);
    assign rd_addr      = cur + {{PAD_W{1'b0}}, widx, 2'b00};
    assign mv_req       = (state == ST_MOVE);
    assign mv_buf_addr  = dscr.buf_ptr;
    assign mv_len       = dscr.ctrl[LEN_W-1:0];
    assign wr_req       = (state == ST_WBACK);
    assign wr_addr      = cur;
    assign wr_data      = {wb_owner, dscr.ctrl[OWNER_BIT-1:0]};
    assign ev_done      = at_done;
    assign ev_eof       = at_done && dscr_is_eof(dscr);
    assign ev_total_eof = at_done && dscr_is_eof(dscr) && dscr_is_last(dscr);
    assign ev_dscr_err  = (state == ST_FAULT);

    // R3: parked means no request of any kind
    assert_park_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        park |-> !(rd_req || wr_req || mv_req));

    // R3: requests are mutually exclusive
    assert_single_req_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_req, wr_req, mv_req}));

endmodule

// File: rtl/dscr_chain_walker.sv
module dscr_chain_walker
    import dcw_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic              ctl_restart,
    input  logic [ADDR_W-1:0] cfg_first_addr,
    input  logic              cfg_check_owner,
    input  logic              cfg_wb_en,
    input  logic              cfg_wb_owner,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [31:0]       rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ack,
    output logic              mv_req,
    output logic [31:0]       mv_buf_addr,
    output logic [11:0]       mv_len,
    input  logic              mv_done,
    output logic              park,
    output logic              ev_dscr_err,
    output logic              ev_done,
    output logic              ev_eof,
    output logic              ev_total_eof,
    output logic [ADDR_W-1:0] hist_cur,
    output logic [ADDR_W-1:0] hist_prev,
    output logic [ADDR_W-1:0] hist_prev2,
    output logic [ADDR_W-1:0] eof_dscr_addr,
    output logic [ADDR_W-1:0] eof_prev_addr
);

    localparam int HIST_DEPTH = 3;

    walk_state_e                       state;
    logic [1:0]                        widx;
    dscr_t                             dscr;
    logic                              hist_load;
    logic [ADDR_W-1:0]                 hist_addr;
    logic                              eof_cap;
    logic [HIST_DEPTH-1:0][ADDR_W-1:0] hist_q;

    dcw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .start      (ctl_start),
        .stop       (ctl_stop),
        .restart    (ctl_restart),
        .chk_owner  (cfg_check_owner),
        .wb_en      (cfg_wb_en),
        .first_addr (cfg_first_addr),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .mv_done    (mv_done),
        .wr_ack     (wr_ack),
        .state      (state),
        .widx       (widx),
        .dscr       (dscr),
        .hist_load  (hist_load),
        .hist_addr  (hist_addr),
        .eof_cap    (eof_cap)
    );

    dcw_hist #(.ADDR_W(ADDR_W), .DEPTH(HIST_DEPTH)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .clr      (soft_rst),
        .load     (hist_load),
        .addr_in  (hist_addr),
        .eof_cap  (eof_cap),
        .hist_q   (hist_q),
        .eof_addr (eof_dscr_addr),
        .eof_prev (eof_prev_addr)
    );

    dcw_port #(.ADDR_W(ADDR_W)) u_port (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .widx         (widx),
        .dscr         (dscr),
        .cur          (hist_q[0]),
        .wb_owner     (cfg_wb_owner),
        .park         (park),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .wr_req       (wr_req),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .mv_req       (mv_req),
        .mv_buf_addr  (mv_buf_addr),
        .mv_len       (mv_len),
        .ev_dscr_err  (ev_dscr_err),
        .ev_done      (ev_done),
        .ev_eof       (ev_eof),
        .ev_total_eof (ev_total_eof)
    );

    assign hist_cur   = hist_q[0];
    assign hist_prev  = hist_q[1];
    assign hist_prev2 = hist_q[2];

    // R2: stop while busy parks on the next clock
    assert_stop_parks_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_stop && !park) |=> park);

    // R11: soft reset parks and empties the history
    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (park && hist_cur == '0 && hist_prev == '0 && eof_dscr_addr == '0));

    // R5: a descriptor error is followed by parking
    assert_fault_parks_R5: assert property (@(posedge clk) disable iff (rst)
        ev_dscr_err |=> park);

    // R10: total end-of-frame only accompanies a finished end-of-frame descriptor
    assert_total_eof_R10: assert property (@(posedge clk) disable iff (rst)
        ev_total_eof |-> (ev_eof && ev_done));

endmodule

// File: tb/dscr_chain_walker_bench.sv
module dscr_chain_walker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 20;
    localparam int WD_LIMIT   = 50000;

    localparam int P_IDLE = 0, P_RD = 1, P_CHK = 2, P_MOVE = 3, P_WB = 4, P_DONE = 5, P_ERR = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic soft_rst = 1'b0, ctl_start = 1'b0, ctl_stop = 1'b0, ctl_restart = 1'b0;
    logic [AW-1:0] cfg_first_addr = '0;
    logic cfg_check_owner = 1'b0, cfg_wb_en = 1'b0, cfg_wb_owner = 1'b0;
    logic rd_req, wr_req, mv_req;
    logic [AW-1:0] rd_addr, wr_addr;
    logic rd_ack = 1'b0, wr_ack = 1'b0, mv_done = 1'b0;
    logic [31:0] rd_data = '0;
    logic [31:0] wr_data, mv_buf_addr;
    logic [11:0] mv_len;
    logic park, ev_dscr_err, ev_done, ev_eof, ev_total_eof;
    logic [AW-1:0] hist_cur, hist_prev, hist_prev2, eof_dscr_addr, eof_prev_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dscr_chain_walker #(.ADDR_W(AW)) u_dscr_chain_walker (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_restart(ctl_restart),
        .cfg_first_addr(cfg_first_addr), .cfg_check_owner(cfg_check_owner),
        .cfg_wb_en(cfg_wb_en), .cfg_wb_owner(cfg_wb_owner),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .mv_req(mv_req), .mv_buf_addr(mv_buf_addr), .mv_len(mv_len), .mv_done(mv_done),
        .park(park), .ev_dscr_err(ev_dscr_err), .ev_done(ev_done), .ev_eof(ev_eof),
        .ev_total_eof(ev_total_eof), .hist_cur(hist_cur), .hist_prev(hist_prev),
        .hist_prev2(hist_prev2), .eof_dscr_addr(eof_dscr_addr), .eof_prev_addr(eof_prev_addr)
    );

    // ---------------- memory and responders ----------------
    logic [31:0] mem [256];
    logic reload = 1'b1;
    logic mv_hold = 1'b0;
    int   mv_cnt = 0;

    task automatic put_dscr(input int a, input logic [31:0] w0, w1, w2);
        mem[a/4]     = w0;
        mem[a/4 + 1] = w1;
        mem[a/4 + 2] = w2;
    endtask

    always @(negedge clk) begin
        if (reload) begin
            for (int i = 0; i < 256; i++) mem[i] = '0;
            put_dscr('h100, 32'h8000_0010, 32'h0000_A000, 32'h0000_0110);
            put_dscr('h110, 32'h8000_0020, 32'h0000_A100, 32'h0000_0120);
            put_dscr('h120, 32'hC000_0008, 32'h0000_A200, 32'h0000_0000);
            put_dscr('h200, 32'h8000_0000, 32'h0000_B000, 32'h0000_0000);
            put_dscr('h220, 32'h8000_0004, 32'h0000_B100, 32'h0000_0302);
            put_dscr('h240, 32'h8000_0004, 32'h0000_B200, 32'h0000_0000);
            put_dscr('h260, 32'hC000_0000, 32'h0000_B300, 32'h0000_0000);
        end
        if (rd_ack) rd_ack <= 1'b0;
        else if (rd_req) begin
            rd_ack  <= 1'b1;
            rd_data <= mem[rd_addr[9:2]];
        end
        if (wr_ack) wr_ack <= 1'b0;
        else if (wr_req) begin
            wr_ack <= 1'b1;
            mem[wr_addr[9:2]] = wr_data;
        end
        if (mv_done) mv_done <= 1'b0;
        else if (mv_req && !mv_hold) begin
            if (mv_cnt >= 2) begin
                mv_done <= 1'b1;
                mv_cnt  <= 0;
            end else mv_cnt <= mv_cnt + 1;
        end else if (!mv_req) mv_cnt <= 0;
    end

    // ---------------- reference model, compared every clock ----------------
    int ph = P_IDLE;
    int wi = 0;
    logic [AW-1:0] mc = '0, mp = '0, mp2 = '0, me = '0, mep = '0;
    logic [31:0] mw0 = '0, mw1 = '0, mw2 = '0;
    int c_checks = 0, c_errs = 0;
    int n_done = 0, n_eof = 0, n_total = 0, n_err = 0;

    task automatic model_step();
        logic bad;
        if (rst || soft_rst) begin
            ph = P_IDLE; wi = 0;
            mc = '0; mp = '0; mp2 = '0; me = '0; mep = '0;
            mw0 = '0; mw1 = '0; mw2 = '0;
        end else begin
            if (ph == P_DONE && mw0[30]) begin
                me  = mc;
                mep = mp;
            end
            if (ctl_stop && ph != P_IDLE) ph = P_IDLE;
            else begin
                case (ph)
                    P_IDLE: begin
                        if (ctl_start) begin
                            mp2 = mp; mp = mc; mc = cfg_first_addr; wi = 0; ph = P_RD;
                        end else if (ctl_restart) begin
                            wi = 0; ph = P_RD;
                        end
                    end
                    P_RD: begin
                        if (rd_ack) begin
                            if (wi == 0) mw0 = rd_data;
                            else if (wi == 1) mw1 = rd_data;
                            else mw2 = rd_data;
                            if (wi == 2) ph = P_CHK;
                            else wi = wi + 1;
                        end
                    end
                    P_CHK: begin
                        bad = (cfg_check_owner && !mw0[31]) ||
                              (mw0[11:0] == 12'd0 && !mw0[30]) || (mw2[1:0] != 2'b00);
                        ph = bad ? P_ERR : P_MOVE;
                    end
                    P_MOVE: if (mv_done) ph = cfg_wb_en ? P_WB : P_DONE;
                    P_WB:   if (wr_ack) ph = P_DONE;
                    P_DONE: begin
                        if (mw2 == 32'd0) ph = P_IDLE;
                        else begin
                            mp2 = mp; mp = mc; mc = mw2[AW-1:0]; wi = 0; ph = P_RD;
                        end
                    end
                    default: ph = P_IDLE;
                endcase
            end
        end
    endtask

    task automatic ccmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        c_checks++;
        if (act !== exp) begin
            c_errs++;
            $display("FAIL %s cycle-compare at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #1;
        if (!rst) begin
            ccmp("R3 park", 32'(park), 32'(ph == P_IDLE));
            ccmp("R1 rd_req", 32'(rd_req), 32'(ph == P_RD));
            if (ph == P_RD) ccmp("R1/R13 rd_addr", 32'(rd_addr), 32'(mc + AW'(4 * wi)));
            ccmp("R9 mv_req", 32'(mv_req), 32'(ph == P_MOVE));
            if (ph == P_MOVE) begin
                ccmp("R9 mv_buf_addr", mv_buf_addr, mw1);
                ccmp("R9 mv_len", 32'(mv_len), 32'(mw0[11:0]));
            end
            ccmp("R7 wr_req", 32'(wr_req), 32'(ph == P_WB));
            if (ph == P_WB) begin
                ccmp("R7 wr_addr", 32'(wr_addr), 32'(mc));
                ccmp("R7 wr_data", wr_data, {cfg_wb_owner, mw0[30:0]});
            end
            ccmp("R5/R6 ev_dscr_err", 32'(ev_dscr_err), 32'(ph == P_ERR));
            ccmp("R9 ev_done", 32'(ev_done), 32'(ph == P_DONE));
            ccmp("R8 ev_eof", 32'(ev_eof), 32'(ph == P_DONE && mw0[30]));
            ccmp("R10 ev_total_eof", 32'(ev_total_eof), 32'(ph == P_DONE && mw0[30] && mw2 == 0));
            ccmp("R4 hist_cur", 32'(hist_cur), 32'(mc));
            ccmp("R4 hist_prev", 32'(hist_prev), 32'(mp));
            ccmp("R4 hist_prev2", 32'(hist_prev2), 32'(mp2));
            ccmp("R8 eof_dscr_addr", 32'(eof_dscr_addr), 32'(me));
            ccmp("R8 eof_prev_addr", 32'(eof_prev_addr), 32'(mep));
            if (ev_done) n_done++;
            if (ev_eof) n_eof++;
            if (ev_total_eof) n_total++;
            if (ev_dscr_err) n_err++;
        end
    end

    // ---------------- directed scenarios ----------------
    int d_checks = 0, d_errs = 0;
    int wd_fail = 0;
    int cyc = 0;

    task automatic dchk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        d_checks++;
        if (act !== exp) begin
            d_errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [AW-1:0] a);
        @(negedge clk);
        cfg_first_addr = a;
        ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
    endtask

    task automatic wait_park();
        while (!park) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            wd_fail = 1;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", c_errs + d_errs + 1, c_checks + d_checks + 1);
            $finish;
        end
    end

    initial begin
        int b_done, b_eof, b_total, b_err;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reload = 1'b0;
        dchk("R3 park after reset", 32'(park), 1);
        dchk("R11 history clear after reset", 32'(hist_cur), 0);

        // R1 R4 R8 R9 R10 R13: full chain with owner check on
        cfg_check_owner = 1'b1;
        pulse_start('h100);
        wait_park();
        dchk("R4 hist_cur after chain", 32'(hist_cur), 'h120);
        dchk("R4 hist_prev after chain", 32'(hist_prev), 'h110);
        dchk("R4 hist_prev2 after chain", 32'(hist_prev2), 'h100);
        dchk("R8 eof_dscr_addr", 32'(eof_dscr_addr), 'h120);
        dchk("R8 eof_prev_addr", 32'(eof_prev_addr), 'h110);
        dchk("R9 done count", 32'(n_done), 3);
        dchk("R10 total eof count", 32'(n_total), 1);

        // R7: write-back with owner 0
        cfg_wb_en = 1'b1; cfg_wb_owner = 1'b0;
        pulse_start('h100);
        wait_park();
        dchk("R7 written control word 0x100", mem['h100/4], 32'h0000_0010);
        dchk("R7 written control word 0x120", mem['h120/4], 32'h4000_0008);
        cfg_wb_en = 1'b0;

        // R5: owner bit now 0 -> error; then check disabled -> accepted
        b_done = n_done; b_err = n_err;
        pulse_start('h100);
        wait_park();
        dchk("R5 owner error raised", 32'(n_err - b_err), 1);
        dchk("R5 no transfer on owner error", 32'(n_done - b_done), 0);
        cfg_check_owner = 1'b0;
        pulse_start('h100);
        wait_park();
        dchk("R5 owner ignored when check off", 32'(n_done - b_done), 3);
        @(negedge clk); reload = 1'b1; @(negedge clk); reload = 1'b0;
        cfg_check_owner = 1'b1;

        // R6: zero length without EOF, misaligned link
        b_err = n_err; b_done = n_done;
        pulse_start('h200);
        wait_park();
        dchk("R6 zero length error", 32'(n_err - b_err), 1);
        pulse_start('h220);
        wait_park();
        dchk("R6 misaligned link error", 32'(n_err - b_err), 2);
        dchk("R6 no transfer on malformed", 32'(n_done - b_done), 0);

        // R13: zero length with EOF is valid
        b_total = n_total;
        pulse_start('h260);
        wait_park();
        dchk("R13 zero-length EOF accepted", 32'(n_total - b_total), 1);
        dchk("R8 eof addr 0x260", 32'(eof_dscr_addr), 'h260);

        // R10: chain ending without EOF
        b_done = n_done; b_eof = n_eof; b_total = n_total;
        pulse_start('h240);
        wait_park();
        dchk("R10 done without eof", 32'(n_done - b_done), 1);
        dchk("R10 no total eof", 32'(n_total - b_total), 0);
        dchk("R8 eof addr unchanged", 32'(eof_dscr_addr), 'h260);

        // R2 R12: stop during move, then restart
        mv_hold = 1'b1;
        pulse_start('h100);
        while (!mv_req) @(negedge clk);
        ctl_stop = 1'b1;
        @(negedge clk);
        ctl_stop = 1'b0;
        dchk("R2 parked after stop", 32'(park), 1);
        dchk("R2 mover request dropped", 32'(mv_req), 0);
        dchk("R12 hist kept at stop", 32'(hist_cur), 'h100);
        mv_hold = 1'b0;
        b_done = n_done;
        ctl_restart = 1'b1;
        @(negedge clk);
        ctl_restart = 1'b0;
        dchk("R12 restart refetches current", 32'(rd_addr), 'h100);
        dchk("R12 restart keeps prev", 32'(hist_prev), 'h240);
        wait_park();
        dchk("R12 chain completes after restart", 32'(n_done - b_done), 3);

        // R11: soft reset mid-run
        pulse_start('h100);
        repeat (4) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        dchk("R11 parked by soft reset", 32'(park), 1);
        dchk("R11 history cleared", 32'(hist_cur | hist_prev | hist_prev2), 0);
        dchk("R11 eof regs cleared", 32'(eof_dscr_addr | eof_prev_addr), 0);
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", c_errs + d_errs + wd_fail, c_checks + d_checks);
        $finish;
    end

endmodule